// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core with Burst Addressing

This block models the control and data path of a synchronous SRAM. The SRAM is pipelined and needs no idle bus cycles between reads and writes. A small array sits inside. Every command (load or advance, read or write, byte mask) is captured on a rising clock edge. Read data leaves the block one enabled edge later. Write data is taken from the bus two enabled edges after its command, so read data and write data fall in the same bus slot and the two can interleave freely.

An access either loads a fresh external address or advances a two-bit burst counter from the last loaded address. The counter steps in linear order or in interleaved order, chosen by a strap input. An active-low clock enable freezes every register and leaves the device selected, which stretches the current cycle. The three-wire chip select works only in the pattern low/high/low. The output drive is gated by an asynchronous active-low output enable and by internal state. The bidirectional bus is modelled as separate input, output and drive-enable signals, with nine bits per byte lane (eight data bits plus parity).

Top module: `pipe_sram`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset with no prior command, d_oe is 0 and d_out is all zeros.
- R2: An access starts only on an enabled edge where sel_a_n=0, sel_b=1 and sel_c_n=0. Any other pattern is a deselect cycle. It moves no data and ends any burst.
- R3: A read whose command is captured at enabled edge n puts its word on d_out after enabled edge n+1.
- R4: Write data for a command captured at enabled edge n is taken from d_in at enabled edge n+2. bw_n[b]=0 writes the whole nine-bit lane d_in[9b+8:9b], parity bit included. bw_n[b]=1 leaves that lane unchanged.
- R5: A read captured on the edge right after a write to the same address returns the new lanes of that write, merged with the old contents of the masked lanes.
- R6: With burst_mode=0, the k-th access of a burst uses low address bits (start+k) mod 4, and the upper bits stay at the loaded value.
- R7: With burst_mode=1, the k-th access of a burst uses low address bits start XOR (k mod 4).
- R8: adv_ld=1 continues the burst in the direction of the load that began it; we_n is ignored on such cycles.
- R9: After a deselect cycle, adv_ld=1 starts no access until a load (adv_ld=0 while selected) happens.
- R10: On an edge with clken_n=1, no register changes. Outputs hold, and the command, data and mask presented on that edge have no effect.
- R11: d_oe is 1 only when oe_n is 0 and a read's data phase is active, and oe_n acts without a clock. d_oe is 0 during a write's data phase and in the cycle after a deselect cycle. d_out is all zeros whenever d_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| clken_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads addr, 1 advances the burst counter |
| we_n | input | 1 | 0 write, 1 read (sampled on loads only) |
| bw_n | input | BYTES | Per-lane write mask, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_mode | input | 1 | 1 interleaved order, 0 linear order |
| addr | input | ADDR_W | External word address |
| d_in | input | BYTES*LANE_W | Write data, nine bits per lane |
| d_out | output | BYTES*LANE_W | Read data; zero when not driving |
| d_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions take several things for granted about the inputs. All inputs are two-state. burst_mode is held constant through each burst. rst_n is released away from a clock edge. The stall, select and gating properties are written so that no further limit is placed on command order: any mix of loads, advances, deselects and stalls is legal. The stimulus drives every input on the falling clock edge and keeps burst_mode fixed from each load until the next load. The result is checked a moment later, inside the same low clock phase.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  // Kind of command presented on an edge.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_DESEL = 2'd1,
    CYC_LOAD  = 2'd2,
    CYC_ADV   = 2'd3
  } cyc_e;

  // True for the single select pattern low/high/low.
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // Low two address bits of the step-th access of a burst.
  function automatic logic [1:0] burst_lo(input logic [1:0] start, input logic [1:0] step,
                                          input logic interleave);
    logic [1:0] r;
    if (interleave) r = start ^ step;
    else            r = start + step;
    return r;
  endfunction

endpackage

// File: rtl/pipe_sram_decode.sv
module pipe_sram_decode
  import pipe_sram_pkg::*;
(
  input  logic sel_a_n,
  input  logic sel_b,
  input  logic sel_c_n,
  input  logic adv_ld,
  input  logic burst_act,
  output cyc_e cyc
);

  always_comb begin
    if (!chip_selected(sel_a_n, sel_b, sel_c_n)) cyc = CYC_DESEL;
    else if (!adv_ld)                            cyc = CYC_LOAD;
    else if (burst_act)                          cyc = CYC_ADV;
    else                                         cyc = CYC_IDLE;
  end

endmodule

// File: rtl/pipe_sram_burst.sv
module pipe_sram_burst
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cyc_e              cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_n,
  input  logic              mode,
  output logic              burst_act,
  output logic              acc_fire,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic              dir_wr_q;
  logic [1:0]        next_step;

  assign next_step = step_q + 2'd1;

  always_comb begin
    acc_fire = en && (cyc == CYC_LOAD || cyc == CYC_ADV);
    acc_wr   = (cyc == CYC_LOAD) ? !we_n : dir_wr_q;
    if (cyc == CYC_ADV)
      acc_addr = {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], next_step, mode)};
    else
      acc_addr = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act <= 1'b0;
      base_q    <= '0;
      step_q    <= '0;
      dir_wr_q  <= 1'b0;
    end else if (en) begin
      unique case (cyc)
        CYC_DESEL: burst_act <= 1'b0;
        CYC_LOAD: begin
          burst_act <= 1'b1;
          base_q    <= addr;
          step_q    <= 2'd0;
          dir_wr_q  <= !we_n;
        end
        CYC_ADV:  step_q <= next_step;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/pipe_sram_lane.sv
module pipe_sram_lane #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              fwd_hit,
  output logic [LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  // Same-edge write to the word being read: pass the bus data through.
  assign rd_data = fwd_hit ? wr_data : mem[rd_addr];

endmodule

// File: rtl/pipe_sram_datapath.sv
module pipe_sram_datapath #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = BYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              acc_fire,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTES-1:0]  acc_bw,
  input  logic [DW-1:0]     d_in,
  output logic              rd_drive,
  output logic [DW-1:0]     rd_data,
  output logic              wr_pend
);

  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [BYTES-1:0]  s1_bw;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTES-1:0]  wr_bw;
  logic [DW-1:0]     lookup;
  logic              same_word;

  assign same_word = wr_pend && (wr_addr == s1_addr);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    pipe_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .wr_fire (en && wr_pend && wr_bw[b]),
      .wr_addr (wr_addr),
      .wr_data (d_in[b*LANE_W +: LANE_W]),
      .rd_addr (s1_addr),
      .fwd_hit (same_word && wr_bw[b]),
      .rd_data (lookup[b*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_bw    <= '0;
      wr_pend  <= 1'b0;
      wr_addr  <= '0;
      wr_bw    <= '0;
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else if (en) begin
      s1_vld   <= acc_fire;
      s1_wr    <= acc_wr;
      s1_addr  <= acc_addr;
      s1_bw    <= acc_bw;
      wr_pend  <= s1_vld && s1_wr;
      wr_addr  <= s1_addr;
      wr_bw    <= s1_bw;
      rd_drive <= s1_vld && !s1_wr;
      if (s1_vld && !s1_wr) rd_data <= lookup;
    end
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = BYTES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clken_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic [BYTES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              burst_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     d_in,
  output logic [DW-1:0]     d_out,
  output logic              d_oe
);

  cyc_e              cyc;
  logic              en;
  logic              burst_act;
  logic              acc_fire, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic              rd_drive, wr_pend;
  logic [DW-1:0]     rd_data;
  logic              desel_ev;

  assign en       = !clken_n;
  assign desel_ev = en && (cyc == CYC_DESEL);

  pipe_sram_decode u_dec (
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .adv_ld    (adv_ld),
    .burst_act (burst_act),
    .cyc       (cyc)
  );

  pipe_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cyc       (cyc),
    .addr      (addr),
    .we_n      (we_n),
    .mode      (burst_mode),
    .burst_act (burst_act),
    .acc_fire  (acc_fire),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr)
  );

  pipe_sram_datapath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .acc_fire (acc_fire),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_bw   (~bw_n),
    .d_in     (d_in),
    .rd_drive (rd_drive),
    .rd_data  (rd_data),
    .wr_pend  (wr_pend)
  );

  assign d_oe  = rd_drive && !oe_n;
  assign d_out = d_oe ? rd_data : '0;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clken_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          adv_ld,
  input logic          burst_act,
  input logic          acc_fire,
  input logic          desel_ev,
  input logic          rd_drive,
  input logic [DW-1:0] rd_data,
  input logic          wr_pend,
  input logic          d_oe
);

  // R2
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (!sel_a_n && sel_b && !sel_c_n && !clken_n));

  // R9
  adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && adv_ld && !burst_act) |-> !acc_fire);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clken_n |=> ($stable(rd_drive) && $stable(rd_data) && $stable(burst_act)));

  // R11
  write_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |-> !d_oe);

  // R11
  after_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev ##1 !clken_n |=> !d_oe);

endmodule

bind pipe_sram pipe_sram_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clken_n   (clken_n),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .adv_ld    (adv_ld),
  .burst_act (burst_act),
  .acc_fire  (acc_fire),
  .desel_ev  (desel_ev),
  .rd_drive  (rd_drive),
  .rd_data   (rd_data),
  .wr_pend   (wr_pend),
  .d_oe      (d_oe)
);

// File: tb/pipe_sram_test.sv
module pipe_sram_test;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = 18;
  localparam int NV = 28;

  typedef struct packed {
    logic          clken_n;
    logic [2:0]    ce;      // {sel_a_n, sel_b, sel_c_n}
    logic          adv;
    logic          we_n;
    logic [NB-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          oe_n;
    logic          mode;
    logic          exp_oe;
    logic [DW-1:0] exp_do;
    logic [3:0]    req;
  } vec_t;

  // Output columns describe the command two rows earlier (R3/R4 timing).
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b010, 1'b0, 1'b0, 2'b00, 6'h04, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd1},  // R1 empty pipe
    '{1'b0, 3'b010, 1'b0, 1'b0, 2'b00, 6'h05, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd1},  // R1
    '{1'b0, 3'b010, 1'b0, 1'b0, 2'b01, 6'h04, 18'h2A5A5, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd11}, // R4 data, R11 quiet
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h04, 18'h15A5A, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd11}, // R11
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h05, 18'h155FF, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd11}, // R4 masked lane
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h04, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h155A5, 4'd5},  // R5 merge
    '{1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 6'h05, 18'h00000, 1'b1, 1'b1, 1'b0, 18'h00000, 4'd11}, // R11 oe_n high
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h155A5, 4'd3},  // R3, R9 adv
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h05, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd11}, // R11 after desel
    '{1'b1, 3'b010, 1'b0, 1'b0, 2'b00, 6'h04, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd9},  // R9, R10 stall
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h04, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd10}, // R10
    '{1'b0, 3'b010, 1'b0, 1'b0, 2'b00, 6'h0A, 18'h00000, 1'b0, 1'b0, 1'b1, 18'h15A5A, 4'd10}, // R10 stretched
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b0, 1'b1, 18'h155A5, 4'd10}, // R10 ignored write
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00011, 1'b0, 1'b0, 1'b0, 18'h00000, 4'd8},  // R8
    '{1'b0, 3'b010, 1'b1, 1'b0, 2'b00, 6'h00, 18'h00022, 1'b0, 1'b0, 1'b0, 18'h00000, 4'd8},  // R8
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h0A, 18'h00033, 1'b0, 1'b0, 1'b0, 18'h00000, 4'd8},  // R8
    '{1'b0, 3'b010, 1'b1, 1'b0, 2'b00, 6'h00, 18'h00044, 1'b0, 1'b0, 1'b0, 18'h00000, 4'd8},  // R8
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b0, 1'b1, 18'h00011, 4'd6},  // R6 0A
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b0, 1'b1, 18'h00022, 4'd6},  // R6 0B
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b0, 1'b1, 18'h00033, 4'd6},  // R6 08
    '{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h0B, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00044, 4'd6},  // R6 09
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00011, 4'd6},  // R6 wrap to 0A
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00022, 4'd7},  // R7 0B
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00011, 4'd7},  // R7 0A
    '{1'b0, 3'b000, 1'b0, 1'b1, 2'b00, 6'h04, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00044, 4'd7},  // R7 09
    '{1'b0, 3'b011, 1'b0, 1'b1, 2'b00, 6'h04, 18'h00000, 1'b0, 1'b1, 1'b1, 18'h00033, 4'd7},  // R7 08
    '{1'b0, 3'b010, 1'b1, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd2},  // R2 sel_b low
    '{1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h00000, 4'd2}   // R2 sel_c_n high
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clken_n, sel_a_n, sel_b, sel_c_n, adv_ld, we_n, oe_n, burst_mode;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in, d_out;
  logic          d_oe;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #5 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .BYTES(NB), .LANE_W(9)) uut (
    .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
    .burst_mode(burst_mode), .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic check(input int req, input int step, input logic eoe, input logic [DW-1:0] edo);
    n_cmp++;
    if (d_oe !== eoe || d_out !== edo) begin
      n_bad++;
      $display("FAIL R%0d step %0d: d_oe=%b exp %b, d_out=%h exp %h", req, step, d_oe, eoe, d_out, edo);
    end
  endtask

  task automatic drive(input vec_t v);
    clken_n = v.clken_n;
    {sel_a_n, sel_b, sel_c_n} = v.ce;
    adv_ld = v.adv; we_n = v.we_n; bw_n = v.bw_n; addr = v.addr;
    d_in = v.din; oe_n = v.oe_n; burst_mode = v.mode;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive('{1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 6'h00, 18'h00000, 1'b0, 1'b1, 1'b0, 18'h0, 4'd1});
    repeat (3) @(negedge clk);
    check(1, -1, 1'b0, '0); // R1 during reset
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check(int'(VECS[i].req), i, VECS[i].exp_oe, VECS[i].exp_do);
    end

    // R10: read of 0x05, then hold the output through a three-edge stall.
    @(negedge clk);
    drive('{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h05, 18'h0, 1'b0, 1'b1, 1'b0, 18'h0, 4'd10});
    @(negedge clk);
    drive('{1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 6'h00, 18'h0, 1'b0, 1'b1, 1'b0, 18'h0, 4'd10});
    @(negedge clk);
    #1 check(3, 100, 1'b1, 18'h15A5A); // R3
    clken_n = 1'b1;
    sel_a_n = 1'b0; adv_ld = 1'b0; we_n = 1'b0; addr = 6'h05; d_in = 18'h3FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 check(10, 101 + k, 1'b1, 18'h15A5A); // R10 held
    end
    // R11: output enable acts without a clock edge.
    oe_n = 1'b1;
    #1 check(11, 104, 1'b0, 18'h00000);
    oe_n = 1'b0;
    #1 check(11, 105, 1'b1, 18'h15A5A);
    // R10: stalled write to 0x05 left the word untouched.
    @(negedge clk);
    drive('{1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h05, 18'h0, 1'b0, 1'b1, 1'b0, 18'h0, 4'd10});
    @(negedge clk);
    drive('{1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 6'h00, 18'h0, 1'b0, 1'b1, 1'b0, 18'h0, 4'd10});
    @(negedge clk);
    #1 check(10, 106, 1'b1, 18'h15A5A);

    // R1: reset in mid-run empties the output pipeline.
    rst_n = 1'b0;
    #1 check(1, 107, 1'b0, 18'h00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check(1, 108, 1'b0, 18'h00000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule